// File: doc/BRIEF.md
# Two-Lane Streaming GHASH Accumulator

This block computes the polynomial authentication hash used by Galois/Counter mode. The field is GF(2^128). It absorbs up to two 128-bit blocks per clock and never needs the message length ahead of time. The caller first loads the hash subkey H. The block then spends one cycle forming H^2 with its own multiplier and raises `ready`. After that it accepts a stream of beats. Each beat carries one or two blocks, a phase tag that says whether they are authenticated data or ciphertext, a byte count for a short final block, and a flag that marks the closing beat.

Every beat is folded into the running value on its own. A beat with two blocks uses H^2 and H. A beat with one block uses only H. A short group at the end of either phase therefore needs no look-ahead. The closing beat supplies the two 64-bit bit lengths. These are folded in as one last block, and the finished hash appears on `digest` for one cycle. The accumulator then returns to zero, ready for the next message under the same key. Producing H, running the counter-mode cipher and masking the tag all happen outside this block.

Top module: `ghash_stream2`

## Requirements
- R1: After reset `ready` is low until a key is loaded. In the cycle after `keyLoad` is sampled `ready` is low, because H^2 is being formed. It is high in the cycle after that, and stays high until the next `keyLoad`.
- R2: A beat with `beatCount`=2 updates the accumulator as X <= (X xor B1)·H^2 xor B2·H. B1 is `beatData[127:0]` and comes first in the message; B2 is `beatData[255:128]`.
- R3: A beat with `beatCount`=1 updates the accumulator as X <= (X xor B1)·H. `beatData[255:128]` has no effect.
- R4: `tailBytes`=k, with k from 1 to 15, keeps the first k bytes of the last valid block of the beat and zeroes the rest. The first byte is bits [127:120]. `tailBytes`=0 keeps the whole block. Earlier blocks in the same beat are never masked.
- R5: A beat with `beatLast`=1 absorbs the block {`lenA`,`lenC`}, with `lenA` in bits [127:64], as X <= (X xor L)·H. Its `beatData` is ignored. `digest` carries the result and `digestValid` is high for exactly the next cycle.
- R6: After a closing beat the accumulator is zero, so the next message is hashed from a fresh start.
- R7: Beats are ignored while `ready` is low, and also when `beatCount` is 0 or 3.
- R8: `beatPhase` 0 marks authenticated data and 1 marks ciphertext. Once a ciphertext beat has been absorbed, later data beats of the same message are ignored. A message may have no data blocks, no ciphertext blocks, or neither.
- R9: `keyLoad` in the middle of a message discards the partial accumulation. The next message starts from zero under the new key.
- R10: Field products follow the reflected bit convention: bit 127 holds the coefficient of x^0, and the reduction polynomial is x^128+x^7+x^2+x+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyLoad | input | 1 | Load `keyIn` as H and restart |
| keyIn | input | 128 | Hash subkey H |
| ready | output | 1 | Beats are accepted |
| beatValid | input | 1 | Beat present |
| beatPhase | input | 1 | 0 = authenticated data, 1 = ciphertext |
| beatCount | input | 2 | Valid blocks in the beat (1 or 2) |
| beatLast | input | 1 | Closing beat carrying the lengths |
| beatData | input | 256 | Two blocks; first block in the low half |
| tailBytes | input | 4 | Valid bytes of the last valid block, 0 = all 16 |
| lenA | input | 64 | Bit length of the authenticated data |
| lenC | input | 64 | Bit length of the ciphertext |
| digest | output | 128 | Finished hash |
| digestValid | output | 1 | One-cycle pulse with `digest` |

## Verification
The bench builds the block with its fixed two-lane, 128-bit geometry and the 64-bit length fields. This lets it compare every digest against a block-at-a-time reference that uses a separately written carry-less multiply. The messages mix pair beats with single beats. They include odd block counts that leave a one-block group at the end of a phase, short tail bytes, and empty phases. A hand-computed product with H = x confirms the bit ordering.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
  localparam int BLK_W  = 128;
  localparam int LANES  = 2;
  localparam int LEN_W  = BLK_W / 2;
  localparam int BYTES  = BLK_W / 8;
  localparam int TAIL_W = $clog2(BYTES);
  localparam int CNT_W  = $clog2(LANES + 2);
  localparam int BEAT_W = BLK_W * LANES;

  typedef logic [BLK_W-1:0] blk_t;

  localparam blk_t RED_POLY = {8'hE1, {(BLK_W-8){1'b0}}};

  typedef enum logic [1:0] {
    ST_NOKEY = 2'd0,
    ST_PREP  = 2'd1,
    ST_RUN   = 2'd2
  } ctrl_state_t;

  typedef struct packed {
    logic loadH;
    logic prepH2;
    logic absorb;
    logic pair;
    logic close;
  } ctrl_t;

  // Zero every byte past the first nb bytes (nb == 0 keeps all of them).
  function automatic blk_t tail_mask(blk_t b, logic [TAIL_W-1:0] nb);
    blk_t r;
    r = b;
    for (int k = 0; k < BYTES; k++) begin
      if (nb != '0 && k >= int'(nb)) r[BLK_W-1-8*k -: 8] = 8'h00;
    end
    return r;
  endfunction
endpackage

// File: rtl/ghash_gfmul.sv
module ghash_gfmul
  import ghash_pkg::*;
(
  input  blk_t opA,
  input  blk_t opB,
  output blk_t prod
);
  blk_t zAcc;
  blk_t vSh;

  // Reflected bit order: opA[BLK_W-1] is the x^0 coefficient.
  always_comb begin
    zAcc = '0;
    vSh  = opB;
    for (int i = 0; i < BLK_W; i++) begin
      if (opA[BLK_W-1-i]) zAcc = zAcc ^ vSh;
      if (vSh[0]) vSh = (vSh >> 1) ^ RED_POLY;
      else        vSh = vSh >> 1;
    end
    prod = zAcc;
  end
endmodule

// File: rtl/ghash_ctrl.sv
module ghash_ctrl
  import ghash_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             keyLoad,
  input  logic             beatValid,
  input  logic             beatPhase,
  input  logic [CNT_W-1:0] beatCount,
  input  logic             beatLast,
  output logic             ready,
  output ctrl_t            strb
);
  ctrl_state_t state, stateNx;
  logic        inCt;
  logic        countOk;
  logic        phaseOk;

  assign countOk = (beatCount == CNT_W'(1)) || (beatCount == CNT_W'(LANES));
  assign phaseOk = !(beatPhase == 1'b0 && inCt);
  assign ready   = (state == ST_RUN);

  always_comb begin
    strb    = '0;
    stateNx = state;
    if (keyLoad) begin
      strb.loadH = 1'b1;
      stateNx    = ST_PREP;
    end else begin
      unique case (state)
        ST_PREP: begin
          strb.prepH2 = 1'b1;
          stateNx     = ST_RUN;
        end
        ST_RUN: begin
          if (beatValid) begin
            if (beatLast) begin
              strb.close = 1'b1;
            end else if (countOk && phaseOk) begin
              strb.absorb = 1'b1;
              strb.pair   = (beatCount == CNT_W'(LANES));
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_NOKEY;
      inCt  <= 1'b0;
    end else begin
      state <= stateNx;
      if (strb.loadH || strb.close) inCt <= 1'b0;
      else if (strb.absorb && beatPhase) inCt <= 1'b1;
    end
  end

  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyLoad |=> !ready);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadH, strb.prepH2, strb.absorb, strb.close}));

  // R8
  phase_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.absorb && beatPhase) |=> (inCt || strb.loadH || strb.close || $past(strb.close)));
endmodule

// File: rtl/ghash_datapath.sv
module ghash_datapath
  import ghash_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             strb,
  input  blk_t              keyIn,
  input  logic [BEAT_W-1:0] beatData,
  input  logic [TAIL_W-1:0] tailBytes,
  input  logic [LEN_W-1:0]  lenA,
  input  logic [LEN_W-1:0]  lenC,
  output blk_t              digest,
  output logic              digestValid
);
  blk_t hPow1, hPow2, accX;
  blk_t lane0, lane1, lane0M, lane1M;
  blk_t lenBlk;
  blk_t mulA1, mulB1, mulP1, mulP2;
  blk_t absorbSum;

  assign lane0  = beatData[BLK_W-1:0];
  assign lane1  = beatData[BEAT_W-1:BLK_W];
  assign lane0M = strb.pair ? lane0 : tail_mask(lane0, tailBytes);
  assign lane1M = tail_mask(lane1, tailBytes);
  assign lenBlk = {lenA, lenC};

  always_comb begin
    if (strb.prepH2) begin
      mulA1 = hPow1;
      mulB1 = hPow1;
    end else if (strb.close) begin
      mulA1 = accX ^ lenBlk;
      mulB1 = hPow1;
    end else begin
      mulA1 = accX ^ lane0M;
      mulB1 = strb.pair ? hPow2 : hPow1;
    end
  end

  ghash_gfmul i_mulHead (.opA(mulA1),  .opB(mulB1), .prod(mulP1));
  ghash_gfmul i_mulTail (.opA(lane1M), .opB(hPow1), .prod(mulP2));

  assign absorbSum = strb.pair ? (mulP1 ^ mulP2) : mulP1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hPow1       <= '0;
      hPow2       <= '0;
      accX        <= '0;
      digest      <= '0;
      digestValid <= 1'b0;
    end else begin
      digestValid <= strb.close;
      if (strb.loadH)  hPow1 <= keyIn;
      if (strb.prepH2) hPow2 <= mulP1;
      if (strb.loadH || strb.close) accX <= '0;
      else if (strb.absorb)         accX <= absorbSum;
      if (strb.close) digest <= mulP1;
    end
  end

  // R6
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    digestValid |-> (accX == '0));

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.absorb && !strb.close && !strb.loadH) |=> $stable(accX));

  // R1
  hpow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.prepH2 |=> $stable(hPow2));
endmodule

// File: rtl/ghash_stream2.sv
module ghash_stream2
  import ghash_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                keyLoad,
  input  logic [BLK_W-1:0]    keyIn,
  output logic                ready,
  input  logic                beatValid,
  input  logic                beatPhase,
  input  logic [CNT_W-1:0]    beatCount,
  input  logic                beatLast,
  input  logic [BEAT_W-1:0]   beatData,
  input  logic [TAIL_W-1:0]   tailBytes,
  input  logic [LEN_W-1:0]    lenA,
  input  logic [LEN_W-1:0]    lenC,
  output logic [BLK_W-1:0]    digest,
  output logic                digestValid
);
  ctrl_t strb;

  ghash_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .keyLoad(keyLoad), .beatValid(beatValid),
    .beatPhase(beatPhase), .beatCount(beatCount), .beatLast(beatLast),
    .ready(ready), .strb(strb)
  );

  ghash_datapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .keyIn(keyIn), .beatData(beatData),
    .tailBytes(tailBytes), .lenA(lenA), .lenC(lenC),
    .digest(digest), .digestValid(digestValid)
  );

  // R5
  digest_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    digestValid |-> $past(ready && beatValid && beatLast && !keyLoad));
endmodule

// File: tb/test_ghash_stream2.sv
`timescale 1ns/1ps
module test_ghash_stream2;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         keyLoad = 1'b0;
  logic [127:0] keyIn = '0;
  logic         ready;
  logic         beatValid = 1'b0;
  logic         beatPhase = 1'b0;
  logic [1:0]   beatCount = '0;
  logic         beatLast = 1'b0;
  logic [255:0] beatData = '0;
  logic [3:0]   tailBytes = '0;
  logic [63:0]  lenA = '0;
  logic [63:0]  lenC = '0;
  logic [127:0] digest;
  logic         digestValid;

  int nTests = 0;
  int nFail  = 0;
  logic [127:0] modelX;

  always #2.5 clk = ~clk;

  ghash_stream2 i_ghash_stream2 (
    .clk(clk), .rstN(rstN), .keyLoad(keyLoad), .keyIn(keyIn), .ready(ready),
    .beatValid(beatValid), .beatPhase(beatPhase), .beatCount(beatCount),
    .beatLast(beatLast), .beatData(beatData), .tailBytes(tailBytes),
    .lenA(lenA), .lenC(lenC), .digest(digest), .digestValid(digestValid)
  );

  // messages: nA, nC, tailA, tailC, singleBeats
  localparam int NMSG = 7;
  localparam int MSG_TBL [NMSG][5] = '{
    '{2, 2, 0,  0, 0},
    '{3, 1, 5,  0, 0},
    '{0, 4, 0,  9, 0},
    '{1, 0, 0,  0, 0},
    '{0, 0, 0,  0, 0},
    '{5, 3, 15, 1, 1},
    '{4, 5, 1,  0, 0}
  };

  localparam logic [127:0] KEY_A = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
  localparam logic [127:0] KEY_B = 128'hb83b533708bf535d0aa6e52980d53b78;

  // Reference product: reflect, carry-less multiply, reduce, reflect back.
  function automatic logic [127:0] refMul(logic [127:0] a, logic [127:0] b);
    logic [127:0] ra, rb, rr, outv;
    logic [254:0] p;
    for (int i = 0; i < 128; i++) begin
      ra[i] = a[127-i];
      rb[i] = b[127-i];
    end
    p = '0;
    for (int i = 0; i < 128; i++) if (ra[i]) p = p ^ (255'(rb) << i);
    for (int i = 254; i >= 128; i--) begin
      if (p[i]) begin
        p[i] = 1'b0;
        p = p ^ (255'(8'h87) << (i - 128));
      end
    end
    rr = p[127:0];
    for (int i = 0; i < 128; i++) outv[127-i] = rr[i];
    return outv;
  endfunction

  function automatic logic [127:0] refMask(logic [127:0] b, int nb);
    logic [127:0] m;
    if (nb == 0) m = '1;
    else m = ~({128{1'b1}} >> (8 * nb));
    return b & m;
  endfunction

  function automatic logic [127:0] mkBlk(int m, int ph, int idx);
    logic [31:0] s;
    logic [127:0] r;
    s = 32'(m * 7919 + ph * 104729 + idx * 31337) ^ 32'hA5C3_0F1E;
    for (int w = 0; w < 4; w++) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      r[32*w +: 32] = s;
    end
    return r;
  endfunction

  function automatic logic [63:0] bitLen(int n, int t);
    if (n == 0) return 64'd0;
    return 64'((n - 1) * 128 + ((t == 0) ? 128 : t * 8));
  endfunction

  task automatic chk(input logic ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleBeat();
    @(negedge clk);
    beatValid = 1'b0;
    beatLast  = 1'b0;
    keyLoad   = 1'b0;
  endtask

  task automatic driveBeat(input logic ph, input logic [1:0] cnt,
                           input logic [255:0] d, input logic [3:0] tb);
    @(negedge clk);
    keyLoad   = 1'b0;
    beatValid = 1'b1;
    beatLast  = 1'b0;
    beatPhase = ph;
    beatCount = cnt;
    beatData  = d;
    tailBytes = tb;
  endtask

  task automatic loadKey(input logic [127:0] k, input logic doCheck);
    @(negedge clk);
    beatValid = 1'b0;
    keyLoad   = 1'b1;
    keyIn     = k;
    @(posedge clk);
    #1;
    if (doCheck) chk(ready == 1'b0, "R1 ready low while H^2 forms", 128'(ready), 128'd0);
    @(negedge clk);
    keyLoad = 1'b0;
    @(posedge clk);
    #1;
    if (doCheck) chk(ready == 1'b1, "R1 ready after prep", 128'(ready), 128'd1);
  endtask

  // Feed one phase; updates modelX block by block.
  task automatic feedPhase(input int m, input int ph, input int n, input int t,
                           input int single, input logic [127:0] hk);
    int pos = 0;
    while (pos < n) begin
      logic [127:0] b0, b1;
      b0 = mkBlk(m, ph, pos);
      b1 = mkBlk(m, ph, pos + 1);
      if (single != 0 || pos + 1 == n) begin
        driveBeat(ph[0], 2'd1, {~b0, b0}, (pos + 1 == n) ? 4'(t) : 4'd0);
        modelX = refMul(modelX ^ refMask(b0, (pos + 1 == n) ? t : 0), hk);
        pos += 1;
      end else begin
        driveBeat(ph[0], 2'd2, {b1, b0}, (pos + 2 == n) ? 4'(t) : 4'd0);
        modelX = refMul(modelX ^ b0, hk);
        modelX = refMul(modelX ^ refMask(b1, (pos + 2 == n) ? t : 0), hk);
        pos += 2;
      end
    end
  endtask

  task automatic closeMsg(input logic [63:0] la, input logic [63:0] lc,
                          input logic [127:0] hk, input string req);
    logic [127:0] expD;
    expD = refMul(modelX ^ {la, lc}, hk);
    @(negedge clk);
    keyLoad   = 1'b0;
    beatValid = 1'b1;
    beatLast  = 1'b1;
    beatCount = 2'd2;
    beatData  = {8{32'hDEAD_BEEF}};
    lenA      = la;
    lenC      = lc;
    @(posedge clk);
    #1;
    chk(digestValid == 1'b1 && digest == expD, req, digest, expD);
    @(negedge clk);
    beatValid = 1'b0;
    beatLast  = 1'b0;
    @(posedge clk);
    #1;
    chk(digestValid == 1'b0, "R5 digest valid is one pulse", 128'(digestValid), 128'd0);
    modelX = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    modelX = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(ready == 1'b0, "R1 reset ready", 128'(ready), 128'd0);
    chk(digestValid == 1'b0, "R5 reset digest valid", 128'(digestValid), 128'd0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(ready == 1'b0, "R1 no key yet", 128'(ready), 128'd0);

    // R10: H = x, one block A = x^127 -> hand-computed hash
    loadKey(128'h4000_0000_0000_0000_0000_0000_0000_0000, 1'b1);
    driveBeat(1'b0, 2'd1, {128'hFFFF, 128'h1}, 4'd0);
    begin
      logic [127:0] expR10;
      expR10 = 128'h7080_0000_0000_0040_0000_0000_0000_0000;
      @(negedge clk);
      beatValid = 1'b1;
      beatLast  = 1'b1;
      lenA      = 64'd128;
      lenC      = 64'd0;
      @(posedge clk);
      #1;
      chk(digestValid && digest == expR10, "R10 reflected product", digest, expR10);
      idleBeat();
    end

    // Table-driven messages (R2 R3 R4 R5 R6 R8), key A
    loadKey(KEY_A, 1'b1);
    for (int m = 0; m < NMSG; m++) begin
      modelX = '0;
      feedPhase(m, 0, MSG_TBL[m][0], MSG_TBL[m][2], MSG_TBL[m][4], KEY_A);
      feedPhase(m, 1, MSG_TBL[m][1], MSG_TBL[m][3], MSG_TBL[m][4], KEY_A);
      closeMsg(bitLen(MSG_TBL[m][0], MSG_TBL[m][2]), bitLen(MSG_TBL[m][1], MSG_TBL[m][3]),
               KEY_A, $sformatf("R2 R3 R4 R6 R8 message %0d digest", m));
    end

    // R7: beats with count 0 and count 3 are ignored
    modelX = '0;
    feedPhase(20, 0, 2, 0, 0, KEY_A);
    driveBeat(1'b0, 2'd0, {2{128'h1234}}, 4'd0);
    driveBeat(1'b1, 2'd3, {2{128'h5678}}, 4'd0);
    feedPhase(20, 1, 1, 0, 0, KEY_A);
    closeMsg(64'd256, 64'd128, KEY_A, "R7 count 0 and 3 ignored");

    // R8: data beat after ciphertext ignored
    modelX = '0;
    feedPhase(21, 0, 1, 0, 0, KEY_A);
    feedPhase(21, 1, 2, 0, 0, KEY_A);
    driveBeat(1'b0, 2'd2, {2{128'hABCD}}, 4'd0);
    closeMsg(64'd128, 64'd256, KEY_A, "R8 late data beat ignored");

    // R9 + R7: key reload mid message, beat during prep ignored
    feedPhase(22, 0, 3, 0, 0, KEY_A);
    @(negedge clk);
    beatValid = 1'b0;
    keyLoad   = 1'b1;
    keyIn     = KEY_B;
    @(negedge clk);
    keyLoad   = 1'b0;
    beatValid = 1'b1;
    beatPhase = 1'b0;
    beatCount = 2'd2;
    beatData  = {2{128'h7777}};
    #0.1;
    chk(ready == 1'b0, "R7 ready low during prep", 128'(ready), 128'd0);
    idleBeat();
    modelX = '0;
    feedPhase(23, 0, 2, 3, 0, KEY_B);
    feedPhase(23, 1, 3, 0, 0, KEY_B);
    closeMsg(64'd152, 64'd384, KEY_B, "R9 restart after reload");

    // R4: tail on the second lane of a pair, first lane unmasked
    modelX = '0;
    feedPhase(24, 1, 2, 7, 0, KEY_B);
    closeMsg(64'd0, 64'd184, KEY_B, "R4 tail on lane two");

    idleBeat();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule